// File: doc/BRIEF.md
# Latency-Modelled Credit FIFO Channel

This block carries words one way from a producing unit to a consuming unit and models the delay of the link between them. Each accepted word passes through a forward delay line and lands in a receive buffer. Each word the consumer removes sends one credit back to the producer through a reverse delay line. The producer may send only while it holds a credit. One credit loop therefore covers both the modelled link delay and the receive storage, and both ends see a plain ready/strobe FIFO interface.

The producer holds as many credits as the buffer has slots. Data arriving at the buffer can therefore never overrun it. When the buffer has at least as many slots as the sum of the two delays, a consumer that always reads keeps the stream at one word per clock. With fewer slots the producer stalls while credits are in flight, and the stream slows to DEPTH words per (FWD_LAT + REV_LAT) clocks.

Top module: `lcc_channel`

## Requirements
- R1: After reset, srcReady is 1, dstReady is 0 and overflowErr is 0.
- R2: The producer starts with DEPTH credits. Each accepted push (srcPush and srcReady both 1 at a rising edge) uses one credit. After DEPTH accepted pushes with no credit returned, srcReady is 0.
- R3: A word accepted at edge t appears on dstData, with dstReady 1, after exactly FWD_LAT rising edges counted from and including t. Before that, dstReady stays 0 if the buffer was empty.
- R4: An accepted pop (dstPop and dstReady both 1 at edge t) returns one credit. The producer's srcReady reflects that credit after exactly REV_LAT edges counted from and including t.
- R5: dstReady is 1 exactly when the receive buffer holds a word. A pop while dstReady is 0 is ignored: it removes nothing and returns no credit.
- R6: A push while srcReady is 0 is dropped and is never delivered. It sets overflowErr to 1 at that edge, and overflowErr stays 1 until reset.
- R7: Words leave in the order they were accepted. A word arriving in the buffer and a pop at the same edge both take effect.
- R8: With DEPTH equal to FWD_LAT + REV_LAT, a producer that pushes whenever srcReady is 1 and a consumer that pops whenever dstReady is 1 move one word per clock.
- R9: With DEPTH smaller than FWD_LAT + REV_LAT, the same producer and consumer move DEPTH words in every FWD_LAT + REV_LAT clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| srcPush | input | 1 | Producer push strobe |
| srcData | input | DATA_W | Producer payload |
| srcReady | output | 1 | Producer holds at least one credit |
| dstPop | input | 1 | Consumer pop strobe |
| dstData | output | DATA_W | Oldest buffered word |
| dstReady | output | 1 | Receive buffer not empty |
| overflowErr | output | 1 | Sticky flag for a push made without a credit |

## Verification
Each result has a fixed due time. srcReady and overflowErr settle one edge after a push. A pushed word reaches dstReady and dstData FWD_LAT edges later, and a popped word's credit reaches srcReady REV_LAT edges later. The bench drives and samples at falling edges and counts edges from the stimulus edge. It checks that the output has not yet changed one edge before the due time and has changed at the due time. Stream rates are counted over a fixed 40-edge window from an idle channel, where the producer's pattern of pushes on allowed edges can be worked out by hand.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  // strobes from the control to the datapath, one per accepted event
  typedef struct packed {
    logic push;  // producer word accepted this cycle
    logic pop;   // consumer read accepted this cycle
  } lccStrobes_t;
endpackage

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lcc_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int REV_LAT = 2,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int RSTG   = (REV_LAT > 1) ? REV_LAT - 1 : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          srcPush,
  input  logic          dstPop,
  input  logic          bufNotEmpty,
  output lccStrobes_t   strobes,
  output logic          srcReady,
  output logic          dstReady,
  output logic          overflowErr,
  output logic [CW-1:0] creditCnt,
  output logic [RSTG-1:0] revVec
);
  logic creditBack;

  assign srcReady    = (creditCnt != '0);
  assign dstReady    = bufNotEmpty;
  assign strobes.push = srcPush & srcReady;
  assign strobes.pop  = dstPop & bufNotEmpty;

  // reverse delay line: a pop becomes a usable credit REV_LAT edges later
  if (REV_LAT > 1) begin : g_revPipe
    logic [RSTG-1:0] revPipe;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        revPipe <= '0;
      end else begin
        revPipe[0] <= strobes.pop;
        for (int i = 1; i < RSTG; i++) revPipe[i] <= revPipe[i-1];
      end
    end
    assign creditBack = revPipe[RSTG-1];
    assign revVec     = revPipe;
  end else begin : g_revDirect
    assign creditBack = strobes.pop;
    assign revVec     = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      creditCnt   <= CW'(DEPTH);
      overflowErr <= 1'b0;
    end else begin
      creditCnt <= creditCnt - CW'(strobes.push) + CW'(creditBack);
      if (srcPush && !srcReady) overflowErr <= 1'b1;
    end
  end
endmodule

// File: rtl/lcc_datapath.sv
module lcc_datapath
  import lcc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 4,
  parameter int FWD_LAT = 2,
  localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int FSTG   = (FWD_LAT > 1) ? FWD_LAT - 1 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lccStrobes_t       strobes,
  input  logic [DATA_W-1:0] srcData,
  output logic [DATA_W-1:0] dstData,
  output logic              bufNotEmpty,
  output logic [CW-1:0]     bufCount,
  output logic [FSTG-1:0]   fwdVec
);
  logic              arriveValid;
  logic [DATA_W-1:0] arriveData;

  // forward delay line; the last stage writes the buffer, so total delay is FWD_LAT
  if (FWD_LAT > 1) begin : g_fwdPipe
    logic [FSTG-1:0]   vld;
    logic [DATA_W-1:0] dat [FSTG];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld <= '0;
      end else begin
        vld[0] <= strobes.push;
        for (int i = 1; i < FSTG; i++) vld[i] <= vld[i-1];
      end
    end
    always_ff @(posedge clk) begin
      dat[0] <= srcData;
      for (int i = 1; i < FSTG; i++) dat[i] <= dat[i-1];
    end
    assign arriveValid = vld[FSTG-1];
    assign arriveData  = dat[FSTG-1];
    assign fwdVec      = vld;
  end else begin : g_fwdDirect
    assign arriveValid = strobes.push;
    assign arriveData  = srcData;
    assign fwdVec      = '0;
  end

  // receive buffer, circular
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (arriveValid) mem[wrPtr] <= arriveData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      bufCount <= '0;
    end else begin
      if (arriveValid) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop) rdPtr <= nextPtr(rdPtr);
      bufCount <= bufCount + CW'(arriveValid) - CW'(strobes.pop);
    end
  end

  assign bufNotEmpty = (bufCount != '0);
  assign dstData     = mem[rdPtr];
endmodule

// File: rtl/lcc_channel.sv
module lcc_channel
  import lcc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FWD_LAT = 2,
  parameter int REV_LAT = 2,
  parameter int DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcPush,
  input  logic [DATA_W-1:0] srcData,
  output logic              srcReady,
  input  logic              dstPop,
  output logic [DATA_W-1:0] dstData,
  output logic              dstReady,
  output logic              overflowErr
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int FSTG = (FWD_LAT > 1) ? FWD_LAT - 1 : 1;
  localparam int RSTG = (REV_LAT > 1) ? REV_LAT - 1 : 1;

  lccStrobes_t     strobes;
  logic            bufNotEmpty;
  logic [CW-1:0]   creditCnt;
  logic [CW-1:0]   bufCount;
  logic [FSTG-1:0] fwdVec;
  logic [RSTG-1:0] revVec;

  lcc_ctrl #(.DEPTH(DEPTH), .REV_LAT(REV_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .srcPush(srcPush), .dstPop(dstPop),
    .bufNotEmpty(bufNotEmpty), .strobes(strobes), .srcReady(srcReady),
    .dstReady(dstReady), .overflowErr(overflowErr),
    .creditCnt(creditCnt), .revVec(revVec)
  );

  lcc_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FWD_LAT(FWD_LAT)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcData(srcData),
    .dstData(dstData), .bufNotEmpty(bufNotEmpty), .bufCount(bufCount),
    .fwdVec(fwdVec)
  );
endmodule

// File: rtl/lcc_checker.sv
module lcc_checker #(
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int FSTG  = 1,
  parameter int RSTG  = 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            srcPush,
  input logic            srcReady,
  input logic            overflowErr,
  input logic [CW-1:0]   creditCnt,
  input logic [CW-1:0]   bufCount,
  input logic [FSTG-1:0] fwdVec,
  input logic [RSTG-1:0] revVec
);
  // R2 / R4: every credit is held by the producer, in flight, buffered or returning
  a_r2_credit_conserved: assert property (@(posedge clk) disable iff (!rstN)
    (int'(creditCnt) + $countones(fwdVec) + int'(bufCount) + $countones(revVec)) == DEPTH);

  a_r2_credit_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(creditCnt) <= DEPTH);

  a_r7_buffer_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(bufCount) <= DEPTH);

  a_r6_overflow_set: assert property (@(posedge clk) disable iff (!rstN)
    (srcPush && !srcReady) |=> overflowErr);

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr |=> overflowErr);
endmodule

bind lcc_channel lcc_checker #(
  .DEPTH(DEPTH), .CW(CW), .FSTG(FSTG), .RSTG(RSTG)
) uChk (
  .clk(clk), .rstN(rstN), .srcPush(srcPush), .srcReady(srcReady),
  .overflowErr(overflowErr), .creditCnt(creditCnt), .bufCount(bufCount),
  .fwdVec(fwdVec), .revVec(revVec)
);

// File: tb/lcc_channel_test.sv
module lcc_channel_test;
  localparam int DW = 8;
  localparam int FL = 2;
  localparam int RL = 2;
  localparam int DA = FL + RL;  // full-rate instance
  localparam int DB = 2;        // throttled instance
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic srcPushA = 0, dstPopA = 0, srcReadyA, dstReadyA, overflowErrA;
  logic srcPushB = 0, dstPopB = 0, srcReadyB, dstReadyB, overflowErrB;
  logic [DW-1:0] srcDataA = '0, srcDataB = '0, dstDataA, dstDataB;

  lcc_channel #(.DATA_W(DW), .FWD_LAT(FL), .REV_LAT(RL), .DEPTH(DA)) uut (
    .clk(clk), .rstN(rstN), .srcPush(srcPushA), .srcData(srcDataA),
    .srcReady(srcReadyA), .dstPop(dstPopA), .dstData(dstDataA),
    .dstReady(dstReadyA), .overflowErr(overflowErrA));

  lcc_channel #(.DATA_W(DW), .FWD_LAT(FL), .REV_LAT(RL), .DEPTH(DB)) uutSmall (
    .clk(clk), .rstN(rstN), .srcPush(srcPushB), .srcData(srcDataB),
    .srcReady(srcReadyB), .dstPop(dstPopB), .dstData(dstDataB),
    .dstReady(dstReadyB), .overflowErr(overflowErrB));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    int pushA, pushB, popA, popB, badA, badB;
    logic [DW-1:0] seqA, seqB, expA, expB;
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    check(srcReadyA == 1, "R1 srcReady", srcReadyA, 1);
    check(dstReadyA == 0, "R1 dstReady", dstReadyA, 0);
    check(overflowErrA == 0 && overflowErrB == 0, "R1 overflowErr", overflowErrA, 0);

    // R5 pop on empty buffer is ignored
    dstPopA = 1; tick(); dstPopA = 0;
    check(dstReadyA == 0, "R5 empty pop", dstReadyA, 0);

    // R3 forward latency
    srcPushA = 1; srcDataA = 8'h11; tick(); srcPushA = 0;
    for (int k = 1; k < FL; k++) begin
      check(dstReadyA == 0, "R3 early", dstReadyA, 0);
      tick();
    end
    check(dstReadyA == 1, "R3 arrival", dstReadyA, 1);
    check(dstDataA == 8'h11, "R3 data", dstDataA, 8'h11);

    // R2 credits exhausted after DEPTH pushes (the ignored pop returned none: R5)
    for (int k = 1; k < DA; k++) begin
      srcPushA = 1; srcDataA = DW'(8'h11 * (k + 1)); tick();
    end
    srcPushA = 0;
    check(srcReadyA == 0, "R2 credits out", srcReadyA, 0);
    repeat (FL) tick();

    // R4 credit return latency
    dstPopA = 1; tick(); dstPopA = 0;
    for (int k = 1; k < RL; k++) begin
      check(srcReadyA == 0, "R4 early", srcReadyA, 0);
      tick();
    end
    check(srcReadyA == 1, "R4 credit back", srcReadyA, 1);

    // R7 order on drain
    for (int k = 1; k < DA; k++) begin
      check(dstDataA == DW'(8'h11 * (k + 1)), "R7 order", dstDataA, 8'h11 * (k + 1));
      dstPopA = 1; tick(); dstPopA = 0;
    end
    check(dstReadyA == 0, "R5 drained", dstReadyA, 0);

    // R6 overflow on the small instance
    srcPushB = 1; srcDataB = 8'hA1; tick();
    srcDataB = 8'hA2; tick();
    check(srcReadyB == 0, "R2 small credits out", srcReadyB, 0);
    srcDataB = 8'hEE; tick(); srcPushB = 0;
    check(overflowErrB == 1, "R6 flag set", overflowErrB, 1);
    repeat (FL) tick();
    check(dstDataB == 8'hA1, "R6 first kept", dstDataB, 8'hA1);
    dstPopB = 1; tick();
    check(dstDataB == 8'hA2, "R6 second kept", dstDataB, 8'hA2);
    tick(); dstPopB = 0;
    repeat (FL + 2) tick();
    check(dstReadyB == 0, "R6 dropped word absent", dstReadyB, 0);
    check(overflowErrB == 1, "R6 sticky", overflowErrB, 1);

    // R7 / R8 / R9 streams from idle
    repeat (RL + 2) tick();
    pushA = 0; pushB = 0; popA = 0; popB = 0; badA = 0; badB = 0;
    seqA = 0; seqB = 0; expA = 0; expB = 0;
    for (int c = 0; c < WIN + 12; c++) begin
      if (dstReadyA) begin
        if (dstDataA != expA) badA++;
        expA++; popA++;
      end
      if (dstReadyB) begin
        if (dstDataB != expB) badB++;
        expB++; popB++;
      end
      dstPopA = dstReadyA; dstPopB = dstReadyB;
      srcPushA = (c < WIN) && srcReadyA;
      srcPushB = (c < WIN) && srcReadyB;
      srcDataA = seqA; srcDataB = seqB;
      if (srcPushA) begin pushA++; seqA++; end
      if (srcPushB) begin pushB++; seqB++; end
      tick();
    end
    dstPopA = 0; dstPopB = 0; srcPushA = 0; srcPushB = 0;
    check(pushA == WIN, "R8 full rate", pushA, WIN);
    check(pushB == WIN * DB / (FL + RL), "R9 throttled", pushB, WIN * DB / (FL + RL));
    check(popA == pushA && popB == pushB, "R7 all delivered", popA + popB, pushA + pushB);
    check(badA == 0 && badB == 0, "R7 stream order", badA + badB, 0);
    check(overflowErrA == 0, "R6 no false flag", overflowErrA, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule